// File: doc/BRIEF.md
# 32-Pin GPIO Port with Atomic Set/Clear

This block is one general-purpose I/O port of 32 pins, controlled through a small memory-mapped register bus. It has two software-writable registers: an output data word and a direction word. Each holds one bit per pin. Software may replace either word with a plain write. It may also change single pins through write-one-to-set and write-one-to-clear alias addresses. This lets a driver change one pin in a single bus write, with no read-modify-write sequence that an interrupt or another core could break.

The pad levels come in through a two-flop synchronizer and can be read at a read-only input address. Each pin's output enable is its direction bit, and its driven level is its output data bit. The bus has no handshake. A write takes effect at the clock edge where the write enable is high. Read data is a combinational function of the address. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gpio_bank32`

## Requirements
- R1: After reset every output data bit and every direction bit is 0, so all `pin_oe` and `pin_out` bits are 0 (every pin is an input).
- R2: A write to offset 0x00 replaces the whole output data word with `bus_wdata`, and a read of 0x00 returns that word.
- R3: A write to offset 0x40 sets each output data bit whose `bus_wdata` bit is 1. A write to 0x44 clears each such bit. In both cases, bits written as 0 keep their value.
- R4: A write to offset 0x08 replaces the whole direction word, and a read of 0x08 returns it. A write to 0x48 sets each direction bit written as 1, and a write to 0x4C clears each such bit; bits written as 0 keep their value.
- R5: `pin_oe[i]` equals direction bit i, where 1 means output. `pin_out[i]` equals output data bit i.
- R6: A read of offset 0x04 returns `pin_in` as sampled two rising clock edges earlier. A write to 0x04 changes no register.
- R7: Reads of 0x40, 0x44, 0x48, 0x4C and of any unmapped offset return 0. Writes to unmapped offsets change no register.
- R8: No register changes in a cycle where `bus_we` is low, whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_out | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Output enable of each pin |
| pin_in | input | 32 | Pad levels, asynchronous to `clk` |

## Verification
The bound checker checks four things on every cycle. A set or clear alias write changes exactly the bits selected by the write data. An idle bus leaves both words stable. Alias and input-register reads agree with the pin ports and the pad history. The pins leave reset as inputs. The bench's scenarios cover what a per-cycle property cannot. These are the sweep of every bit position through both alias pairs, the exact edge at which a new pad level becomes readable, and writes to the read-only and unmapped offsets, followed by readback of both words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BUS_W = 32;

  localparam int unsigned OFS_DOUT     = 'h00;
  localparam int unsigned OFS_DIN      = 'h04;
  localparam int unsigned OFS_DIR      = 'h08;
  localparam int unsigned OFS_DOUT_SET = 'h40;
  localparam int unsigned OFS_DOUT_CLR = 'h44;
  localparam int unsigned OFS_DIR_SET  = 'h48;
  localparam int unsigned OFS_DIR_CLR  = 'h4C;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
  } reg_op_t;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_DOUT = 2'd1,
    RSEL_DIN  = 2'd2,
    RSEL_DIR  = 2'd3
  } rd_sel_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_op_t           dout_op,
  output reg_op_t           dir_op,
  output rd_sel_t           rd_sel
);

  always_comb begin
    dout_op = '0;
    dir_op  = '0;
    if (we) begin
      dout_op.load = (addr == ADDR_W'(OFS_DOUT));
      dout_op.set  = (addr == ADDR_W'(OFS_DOUT_SET));
      dout_op.clr  = (addr == ADDR_W'(OFS_DOUT_CLR));
      dir_op.load  = (addr == ADDR_W'(OFS_DIR));
      dir_op.set   = (addr == ADDR_W'(OFS_DIR_SET));
      dir_op.clr   = (addr == ADDR_W'(OFS_DIR_CLR));
    end
  end

  always_comb begin
    if (addr == ADDR_W'(OFS_DOUT))     rd_sel = RSEL_DOUT;
    else if (addr == ADDR_W'(OFS_DIN)) rd_sel = RSEL_DIN;
    else if (addr == ADDR_W'(OFS_DIR)) rd_sel = RSEL_DIR;
    else                               rd_sel = RSEL_ZERO;
  end

endmodule

// File: rtl/gpio_bank_bitreg.sv
module gpio_bank_bitreg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_op_t      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = op.load | op.set | op.clr;
    d  = q;
    if (op.load)     d = wdata;
    else if (op.set) d = q | wdata;
    else if (op.clr) d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][W-1:0] stage_q;
  logic [DEPTH-1:0][W-1:0] stage_d;

  always_comb stage_d = {stage_q[DEPTH-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/gpio_bank32.sv
module gpio_bank32
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned PIN_COUNT   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  input  logic [PIN_COUNT-1:0] pin_in
);

  logic                 rst_core_n;
  reg_op_t              dout_op;
  reg_op_t              dir_op;
  rd_sel_t              rd_sel;
  logic [PIN_COUNT-1:0] dout_q;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] din_s;

  // Reset release synchronizer: assert asynchronously, release on clk.
  gpio_bank_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (1'b1),
    .dout  (rst_core_n)
  );

  gpio_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .we      (bus_we),
    .dout_op (dout_op),
    .dir_op  (dir_op),
    .rd_sel  (rd_sel)
  );

  gpio_bank_bitreg #(.W(PIN_COUNT)) u_dout_reg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .op    (dout_op),
    .wdata (bus_wdata[PIN_COUNT-1:0]),
    .q     (dout_q)
  );

  gpio_bank_bitreg #(.W(PIN_COUNT)) u_dir_reg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .op    (dir_op),
    .wdata (bus_wdata[PIN_COUNT-1:0]),
    .q     (dir_q)
  );

  gpio_bank_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_pad_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (pin_in),
    .dout  (din_s)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (rd_sel)
      RSEL_DOUT: bus_rdata[PIN_COUNT-1:0] = dout_q;
      RSEL_DIN:  bus_rdata[PIN_COUNT-1:0] = din_s;
      RSEL_DIR:  bus_rdata[PIN_COUNT-1:0] = dir_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_bank32_chk.sv
module gpio_bank32_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PIN_COUNT = 32
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic [PIN_COUNT-1:0] pin_in
);

  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFS_DOUT);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_OSET = ADDR_W'(OFS_DOUT_SET);
  localparam logic [ADDR_W-1:0] A_OCLR = ADDR_W'(OFS_DOUT_CLR);
  localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(OFS_DIR_SET);
  localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(OFS_DIR_CLR);

  logic [PIN_COUNT-1:0] wmask;
  logic [1:0]           live_cnt;
  logic [1:0]           live_nxt;

  assign wmask = bus_wdata[PIN_COUNT-1:0];

  always_comb live_nxt = (live_cnt == 2'd3) ? live_cnt : live_cnt + 2'd1;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) live_cnt <= '0;
    else             live_cnt <= live_nxt;
  end

  // R1: pins leave reset as inputs driving 0
  a_r1_reset_inputs: assert property (@(posedge clk)
    $rose(rst_core_n) |-> (pin_oe == '0) && (pin_out == '0));

  // R3: output set alias touches only selected bits
  a_r3_out_set: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_OSET) |=>
      (pin_out == ($past(pin_out) | $past(wmask))) && $stable(pin_oe));

  // R3: output clear alias touches only selected bits
  a_r3_out_clr: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_OCLR) |=>
      (pin_out == ($past(pin_out) & ~$past(wmask))) && $stable(pin_oe));

  // R4: direction set alias
  a_r4_dir_set: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_DSET) |=>
      (pin_oe == ($past(pin_oe) | $past(wmask))) && $stable(pin_out));

  // R4: direction clear alias
  a_r4_dir_clr: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_DCLR) |=>
      (pin_oe == ($past(pin_oe) & ~$past(wmask))) && $stable(pin_out));

  // R5: register readback agrees with the pin ports
  a_r5_dir_pins: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == A_DIR) |-> bus_rdata[PIN_COUNT-1:0] == pin_oe);

  a_r5_out_pins: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == A_DOUT) |-> bus_rdata[PIN_COUNT-1:0] == pin_out);

  // R6: input register shows the pad two edges back
  a_r6_din_delay: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == A_DIN && live_cnt >= 2'd2) |->
      bus_rdata[PIN_COUNT-1:0] == $past(pin_in, 2));

  // R7: alias offsets read zero
  a_r7_alias_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == A_OSET || bus_addr == A_OCLR ||
     bus_addr == A_DSET || bus_addr == A_DCLR) |-> bus_rdata == '0);

  // R8: an idle bus leaves both words unchanged
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_we |=> $stable(pin_out) && $stable(pin_oe));

endmodule

bind gpio_bank32 gpio_bank32_chk #(
  .ADDR_W    (ADDR_W),
  .PIN_COUNT (PIN_COUNT)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .pin_in     (pin_in)
);

// File: tb/gpio_bank32_test.sv
`timescale 1ns/1ps
module gpio_bank32_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [31:0] pin_in;

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 1'b0;
  logic [31:0] out_m;
  logic [31:0] dir_m;
  logic [31:0] lfsr;

  always #5 clk = ~clk;

  gpio_bank32 uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_in    (pin_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    check({tag, " pin_out"}, pin_out, out_m);
    check({tag, " pin_oe"}, pin_oe, dir_m);
    rd(8'h00, v); check({tag, " read 0x00"}, v, out_m);
    rd(8'h08, v); check({tag, " read 0x08"}, v, dir_m);
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    out_m = '0; dir_m = '0; lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_state("R1 reset");

    // R2: direct output writes
    wr(8'h00, 32'hA5A5_5A5A); out_m = 32'hA5A5_5A5A; check_state("R2 direct");
    wr(8'h00, 32'h0000_0001); out_m = 32'h0000_0001; check_state("R2 direct");

    // R3: sweep every bit through set then clear
    wr(8'h00, 32'h0); out_m = '0;
    for (int i = 0; i < 32; i++) begin
      wr(8'h40, 32'h1 << i); out_m |= 32'h1 << i; check_state("R3 set sweep");
    end
    for (int i = 0; i < 32; i++) begin
      wr(8'h44, 32'h1 << i); out_m &= ~(32'h1 << i); check_state("R3 clr sweep");
    end
    wr(8'h40, 32'h0); check_state("R3 set zero mask");

    // R4, R5: direction sweep with output data held
    wr(8'h00, 32'hDEAD_BEEF); out_m = 32'hDEAD_BEEF;
    for (int i = 0; i < 32; i++) begin
      wr(8'h48, 32'h1 << i); dir_m |= 32'h1 << i; check_state("R4 R5 dir set sweep");
    end
    for (int i = 31; i >= 0; i--) begin
      wr(8'h4C, 32'h1 << i); dir_m &= ~(32'h1 << i); check_state("R4 R5 dir clr sweep");
    end
    wr(8'h08, 32'h0F0F_00FF); dir_m = 32'h0F0F_00FF; check_state("R4 dir direct");

    // R2 R3 R4: mixed pseudo-random operations
    for (int k = 0; k < 120; k++) begin
      lfsr = step(lfsr);
      case (k % 6)
        0: begin wr(8'h00, lfsr); out_m = lfsr; end
        1: begin wr(8'h40, lfsr); out_m |= lfsr; end
        2: begin wr(8'h44, lfsr); out_m &= ~lfsr; end
        3: begin wr(8'h08, lfsr); dir_m = lfsr; end
        4: begin wr(8'h48, lfsr); dir_m |= lfsr; end
        default: begin wr(8'h4C, lfsr); dir_m &= ~lfsr; end
      endcase
      check_state("R2 R3 R4 mixed");
    end

    // R7: alias and unmapped reads are zero, unmapped writes ignored
    rd(8'h40, v); check("R7 read 0x40", v, 32'h0);
    rd(8'h44, v); check("R7 read 0x44", v, 32'h0);
    rd(8'h48, v); check("R7 read 0x48", v, 32'h0);
    rd(8'h4C, v); check("R7 read 0x4C", v, 32'h0);
    rd(8'h10, v); check("R7 read 0x10", v, 32'h0);
    rd(8'h41, v); check("R7 read 0x41", v, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF); check_state("R7 unmapped write 0x10");
    wr(8'h01, 32'h1234_0000); check_state("R7 unmapped write 0x01");
    wr(8'hFC, 32'h5555_AAAA); check_state("R7 unmapped write 0xFC");

    // R8: bus data with write enable low changes nothing
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = ~out_m; bus_we = 1'b0;
    @(negedge clk);
    bus_addr = 8'h48; bus_wdata = ~dir_m;
    @(negedge clk);
    check_state("R8 idle");

    // R6: two-edge input latency, then writes to 0x04 ignored
    rd(8'h04, v); check("R6 din initial", v, 32'h0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] prev;
      lfsr = step(lfsr);
      rd(8'h04, prev);
      pin_in = lfsr;
      @(negedge clk);
      rd(8'h04, v); check("R6 din after one edge", v, prev);
      @(negedge clk);
      rd(8'h04, v); check("R6 din after two edges", v, lfsr);
    end
    wr(8'h04, ~pin_in); check_state("R6 write to input offset");
    rd(8'h04, v); check("R6 din after write", v, pin_in);

    // R1: reset again from a non-zero state
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 async pin_oe", pin_oe, 32'h0);
    check("R1 async pin_out", pin_out, 32'h0);
    out_m = '0; dir_m = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 second reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule